// File: doc/BRIEF.md
# Triggered Pipeline and Readout Buffer

This block delays the per-crossing link data by a fixed number of clock cycles, so that a trigger decision that arrives late can still pick out the crossing it refers to. Each clock cycle is one bunch crossing. Every cycle, one word is pushed into a delay line: 16 bits for each link, 48 bits for three links. The host sets the delay through a register and applies it with a synchronous pipeline reset. When a trigger-accept pulse arrives, the word leaving the delay line is copied into a readout FIFO. Any word that is not accepted is simply overwritten.

A downstream readout controller drains the FIFO. A readout-start pulse latches a valid-pattern vector. It has one bit per link, and the bit is set when that link's field of the oldest buffered entry is non-zero, so the controller can send the vector as the first word of a block. After that, each request on the request line is answered one cycle later with an acknowledge and one 16-bit word. The words of an entry come out link 0 first, and the entry leaves the FIFO after its last word.

A small host register port gives access to the programmed depth, the pipeline flags, the FIFO word count and flags, and a sticky overflow bit.

Top module: `trig_readout_buf`

## Requirements
- R1: After `rst`, the depth register reads 16, the pipeline empty flag (register 0 bit 12) is 1, and its full flag (bit 13) is 0. Register 1 reads count 0, empty (bit 12) 1, full (bit 13) 0 and overflow (bit 14) 0. `roAck` and `validPattern` are 0.
- R2: A host write to address 0 stores `regWdata[8:0]` as the depth. Reading address 0 returns that value in bits 8..0.
- R3: Once the pipeline is full, a trigger sampled at clock edge t stores the `linkData` word that was sampled at edge t−D, where D is the active depth.
- R4: After a pipeline reset, register 0 bit 12 is 1. Bit 13 becomes 1 exactly D edges later. A trigger that arrives before bit 13 is set is ignored: the count does not change and no overflow is flagged.
- R5: Writing a new depth does not change the delay or the full flag. The new value takes effect only at the next `pipeRst`.
- R6: Register 1 gives the number of buffered entries in bits 7..0, a full flag in bit 13 and an empty flag in bit 12. The FIFO holds 128 entries.
- R7: A trigger that arrives while the FIFO is full is dropped, and the count stays at 128. It sets register 1 bit 14, which stays set until `rst`.
- R8: Once `roStart` has been seen, a request sampled while the FIFO is not empty produces `roAck` high for exactly the next cycle. `roData` carries link 0 (bits 15..0 of the entry), then link 1, then link 2 on successive requests. The entry is removed after its third word.
- R9: A request is not acknowledged while the FIFO is empty, or before any `roStart` since reset.
- R10: `roStart` latches `validPattern`. Bit i is 1 when link i's 16-bit field of the oldest entry is non-zero, and all bits are 0 when the FIFO is empty. The value is held until the next `roStart`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per bunch crossing |
| rst | input | 1 | Synchronous reset, active high |
| pipeRst | input | 1 | Synchronous pipeline pointer reset; loads the programmed depth |
| linkData | input | 48 | Concatenated link words for this crossing, link 0 in bits 15..0 |
| trigAccept | input | 1 | Trigger-accept pulse |
| roStart | input | 1 | Readout start pulse |
| roReq | input | 1 | Readout request, one word per sampled cycle |
| roAck | output | 1 | Request acknowledge |
| roData | output | 16 | Readout word |
| validPattern | output | 3 | Per-link non-zero flags of the oldest entry, latched at start |
| regAddr | input | 1 | Register select: 0 pipeline control/status, 1 FIFO status |
| regWr | input | 1 | Register write strobe |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data, combinational |

## Verification
Register reads are combinational, so the bench reads them in the same cycle it selects the address. A trigger or request takes effect at the edge that samples it. The FIFO count, `roAck`, `roData` and `validPattern` therefore change right after that edge, and the bench checks them at the following falling edge. `roAck` is checked again one cycle later to confirm it has fallen. The pipeline full flag is due exactly D edges after the edge that samples `pipeRst`, so the bench counts edges and checks both D−1 and D. Captured words are predicted from a bench-side history of every driven `linkData` value, indexed by edge number, taking the entry D edges before the trigger edge.

// File: rtl/trb_pkg.sv
package trb_pkg;
  localparam int SEL_W = 2;

  typedef struct packed {
    logic pipeClr;
    logic pipeShift;
    logic daqPush;
    logic daqPop;
    logic loadWord;
    logic latchPattern;
    logic [SEL_W-1:0] wordSel;
  } trbStrobe_t;
endpackage

// File: rtl/trb_ctrl.sv
module trb_ctrl
  import trb_pkg::*;
#(
  parameter int LINKS     = 3,
  parameter int DEPTH_W   = 9,
  parameter int CNT_W     = 8,
  parameter int DEPTH_RST = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pipeRst,
  input  logic             trigAccept,
  input  logic             roStart,
  input  logic             roReq,
  input  logic             regAddr,
  input  logic             regWr,
  input  logic [DEPTH_W-1:0] regWdata,
  input  logic             daqEmpty,
  input  logic             daqFull,
  input  logic [CNT_W-1:0] daqCount,
  output trbStrobe_t       strb,
  output logic             roAck,
  output logic [15:0]      regRdata
);
  localparam logic [DEPTH_W-1:0] RST_DEPTH = (DEPTH_RST == 0) ? DEPTH_W'(1) : DEPTH_W'(DEPTH_RST);
  localparam logic [SEL_W-1:0]   LAST_SEL  = SEL_W'(LINKS - 1);

  logic [DEPTH_W-1:0] depthReg, activeDepth, fill;
  logic               primed, pipeEmpty, overflow, started, ackGo, lastWord;
  logic [SEL_W-1:0]   wordSel;

  assign primed    = (fill == activeDepth);
  assign pipeEmpty = (fill == '0);
  assign lastWord  = (wordSel == LAST_SEL);
  assign ackGo     = roReq && started && !daqEmpty && !roStart;

  always_ff @(posedge clk) begin
    if (rst) depthReg <= DEPTH_W'(DEPTH_RST);
    else if (regWr && regAddr == 1'b0) depthReg <= regWdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill        <= '0;
      activeDepth <= RST_DEPTH;
    end else if (pipeRst) begin
      fill        <= '0;
      activeDepth <= (depthReg == '0) ? DEPTH_W'(1) : depthReg;
    end else if (!primed) begin
      fill <= fill + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) overflow <= 1'b0;
    else if (trigAccept && primed && daqFull && !pipeRst) overflow <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      started <= 1'b0;
      wordSel <= '0;
      roAck   <= 1'b0;
    end else begin
      roAck <= ackGo;
      if (roStart) begin
        started <= 1'b1;
        wordSel <= '0;
      end else if (ackGo) begin
        wordSel <= lastWord ? '0 : wordSel + 1'b1;
      end
    end
  end

  always_comb begin
    strb.pipeClr      = pipeRst;
    strb.pipeShift    = primed && !pipeRst;
    strb.daqPush      = trigAccept && primed && !daqFull && !pipeRst;
    strb.daqPop       = ackGo && lastWord;
    strb.loadWord     = ackGo;
    strb.latchPattern = roStart;
    strb.wordSel      = wordSel;
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == 1'b0) begin
      regRdata[DEPTH_W-1:0] = depthReg;
      regRdata[13]          = primed;
      regRdata[12]          = pipeEmpty;
    end else begin
      regRdata[CNT_W-1:0] = daqCount;
      regRdata[14]        = overflow;
      regRdata[13]        = daqFull;
      regRdata[12]        = daqEmpty;
    end
  end

  // R8
  ack_after_req_chk: assert property (@(posedge clk) disable iff (rst) roAck |-> $past(roReq));
  // R9
  no_ack_when_empty_chk: assert property (@(posedge clk) disable iff (rst) (roReq && daqEmpty) |=> !roAck);
  // R7
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst) overflow |=> overflow);
  // R4
  fill_bound_chk: assert property (@(posedge clk) disable iff (rst) fill <= activeDepth);
  // R5
  depth_hold_chk: assert property (@(posedge clk) disable iff (rst) !pipeRst |=> $stable(activeDepth));
endmodule

// File: rtl/trb_datapath.sv
module trb_datapath
  import trb_pkg::*;
#(
  parameter int LINKS   = 3,
  parameter int LINK_W  = 16,
  parameter int PIPE_AW = 9,
  parameter int DAQ_AW  = 7,
  parameter int CNT_W   = DAQ_AW + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LINKS*LINK_W-1:0] linkData,
  input  trbStrobe_t              strb,
  output logic                    daqEmpty,
  output logic                    daqFull,
  output logic [CNT_W-1:0]        daqCount,
  output logic [LINK_W-1:0]       roData,
  output logic [LINKS-1:0]        validPattern
);
  localparam int WORD_W    = LINKS * LINK_W;
  localparam int PIPE_SZ   = 1 << PIPE_AW;
  localparam int DAQ_DEPTH = 1 << DAQ_AW;

  logic [WORD_W-1:0]  pipeMem [PIPE_SZ];
  logic [WORD_W-1:0]  daqMem  [DAQ_DEPTH];
  logic [PIPE_AW-1:0] wrPtr, rdPtr;
  logic [DAQ_AW-1:0]  daqWp, daqRp;
  logic [WORD_W-1:0]  pipeOut, head;
  logic [LINKS-1:0]   headNz;

  always_ff @(posedge clk) pipeMem[wrPtr] <= linkData;

  always_ff @(posedge clk) begin
    if (rst || strb.pipeClr) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      wrPtr <= wrPtr + 1'b1;
      if (strb.pipeShift) rdPtr <= rdPtr + 1'b1;
    end
  end

  assign pipeOut = pipeMem[rdPtr];

  always_ff @(posedge clk) if (strb.daqPush) daqMem[daqWp] <= pipeOut;

  always_ff @(posedge clk) begin
    if (rst) begin
      daqWp    <= '0;
      daqRp    <= '0;
      daqCount <= '0;
    end else begin
      if (strb.daqPush) daqWp <= daqWp + 1'b1;
      if (strb.daqPop)  daqRp <= daqRp + 1'b1;
      case ({strb.daqPush, strb.daqPop})
        2'b10:   daqCount <= daqCount + 1'b1;
        2'b01:   daqCount <= daqCount - 1'b1;
        default: daqCount <= daqCount;
      endcase
    end
  end

  assign daqEmpty = (daqCount == '0);
  assign daqFull  = (daqCount == CNT_W'(DAQ_DEPTH));
  assign head     = daqMem[daqRp];

  for (genvar i = 0; i < LINKS; i++) begin : g_nz
    assign headNz[i] = |head[i*LINK_W +: LINK_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      roData       <= '0;
      validPattern <= '0;
    end else begin
      if (strb.loadWord) roData <= head[int'(strb.wordSel)*LINK_W +: LINK_W];
      if (strb.latchPattern) validPattern <= daqEmpty ? '0 : headNz;
    end
  end

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (rst) daqCount <= CNT_W'(DAQ_DEPTH));
  // R7
  full_holds_chk: assert property (@(posedge clk) disable iff (rst) (daqFull && !strb.daqPop) |=> daqFull);
  // R9
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (rst) daqEmpty |-> !strb.daqPop);
endmodule

// File: rtl/trig_readout_buf.sv
module trig_readout_buf
  import trb_pkg::*;
#(
  parameter int LINKS     = 3,
  parameter int LINK_W    = 16,
  parameter int DEPTH_W   = 9,
  parameter int DAQ_AW    = 7,
  parameter int DEPTH_RST = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pipeRst,
  input  logic [LINKS*LINK_W-1:0] linkData,
  input  logic                    trigAccept,
  input  logic                    roStart,
  input  logic                    roReq,
  output logic                    roAck,
  output logic [LINK_W-1:0]       roData,
  output logic [LINKS-1:0]        validPattern,
  input  logic                    regAddr,
  input  logic                    regWr,
  input  logic [15:0]             regWdata,
  output logic [15:0]             regRdata
);
  localparam int CNT_W = DAQ_AW + 1;

  trbStrobe_t       strb;
  logic             daqEmpty, daqFull;
  logic [CNT_W-1:0] daqCount;
  logic             unusedWdata;

  assign unusedWdata = ^regWdata[15:DEPTH_W];

  trb_ctrl #(.LINKS(LINKS), .DEPTH_W(DEPTH_W), .CNT_W(CNT_W), .DEPTH_RST(DEPTH_RST)) u_ctrl (
    .clk(clk), .rst(rst), .pipeRst(pipeRst), .trigAccept(trigAccept),
    .roStart(roStart), .roReq(roReq), .regAddr(regAddr), .regWr(regWr),
    .regWdata(regWdata[DEPTH_W-1:0]), .daqEmpty(daqEmpty), .daqFull(daqFull),
    .daqCount(daqCount), .strb(strb), .roAck(roAck), .regRdata(regRdata)
  );

  trb_datapath #(.LINKS(LINKS), .LINK_W(LINK_W), .PIPE_AW(DEPTH_W), .DAQ_AW(DAQ_AW), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .linkData(linkData), .strb(strb), .daqEmpty(daqEmpty),
    .daqFull(daqFull), .daqCount(daqCount), .roData(roData), .validPattern(validPattern)
  );
endmodule

// File: tb/trig_readout_buf_bench.sv
module trig_readout_buf_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1, pipeRst = 1'b0, trigAccept = 1'b0, roStart = 1'b0, roReq = 1'b0;
  logic [47:0] linkData;
  logic        roAck, regAddr = 1'b0, regWr = 1'b0;
  logic [15:0] roData, regWdata = '0, regRdata;
  logic [2:0]  validPattern;

  always #5 clk = ~clk;

  trig_readout_buf u_trig_readout_buf (
    .clk(clk), .rst(rst), .pipeRst(pipeRst), .linkData(linkData), .trigAccept(trigAccept),
    .roStart(roStart), .roReq(roReq), .roAck(roAck), .roData(roData),
    .validPattern(validPattern), .regAddr(regAddr), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata)
  );

  int          edgeCnt = 0;
  int          checks = 0, fails = 0, dModel = 16;
  bit          done = 0;
  logic [2:0]  zeroMask = '0;
  logic [47:0] hist [8192];
  logic [47:0] mq [$];

  function automatic logic [47:0] mk(int n, logic [2:0] m);
    logic [47:0] w;
    w = {16'(n * 7 + 3), 16'(n * 5 + 1), 16'(n * 3 + 2)};
    for (int i = 0; i < 3; i++) if (m[i]) w[i*16 +: 16] = '0;
    return w;
  endfunction

  always @(posedge clk) edgeCnt <= edgeCnt + 1;
  always @(negedge clk) begin
    linkData <= mk(edgeCnt + 1, zeroMask);
    hist[(edgeCnt + 1) % 8192] <= mk(edgeCnt + 1, zeroMask);
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rdReg(input logic a, output logic [15:0] v);
    regAddr = a;
    #1 v = regRdata;
  endtask

  task automatic wrDepth(input logic [15:0] v);
    regAddr = 1'b0; regWdata = v; regWr = 1'b1;
    tick;
    regWr = 1'b0;
  endtask

  task automatic pipeReset(input int d);
    pipeRst = 1'b1;
    tick;
    pipeRst = 1'b0;
    dModel = d;
  endtask

  task automatic fire(input bit counts);
    int te;
    te = edgeCnt + 1;
    trigAccept = 1'b1;
    tick;
    trigAccept = 1'b0;
    if (counts && mq.size() < 128) mq.push_back(hist[(te - dModel) % 8192]);
  endtask

  task automatic startRo;
    roStart = 1'b1;
    tick;
    roStart = 1'b0;
  endtask

  task automatic readWord(input logic [15:0] exp, input string tag);
    roReq = 1'b1;
    tick;
    roReq = 1'b0;
    chk(roAck === 1'b1, "R8 ack", 64'(roAck), 1);
    chk(roData === exp, tag, 64'(roData), 64'(exp));
    tick;
    chk(roAck === 1'b0, "R8 ack one cycle", 64'(roAck), 0);
  endtask

  task automatic readEntry(input string tag);
    logic [47:0] e;
    e = mq.pop_front();
    for (int i = 0; i < 3; i++) readWord(e[i*16 +: 16], tag);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rst = 1'b1;
    repeat (3) tick;
    rst = 1'b0;
    dModel = 16;
    rdReg(1'b0, v);
    chk(v[8:0] == 9'd16, "R1 depth", 64'(v[8:0]), 16);
    chk(v[13:12] == 2'b01, "R1 pipe flags", 64'(v[13:12]), 1);
    rdReg(1'b1, v);
    chk(v[14:12] == 3'b001 && v[7:0] == 0, "R1 fifo status", 64'(v), 64'h1000);
    chk(roAck === 1'b0 && validPattern === 3'b000, "R1 readout outputs", 64'({roAck, validPattern}), 0);
  endtask

  task automatic t_depth_rw;
    logic [15:0] v;
    wrDepth(16'hFFFF);
    rdReg(1'b0, v);
    chk(v[8:0] == 9'h1FF, "R2 depth all ones", 64'(v[8:0]), 64'h1FF);
    wrDepth(16'd5);
    rdReg(1'b0, v);
    chk(v[8:0] == 9'd5, "R2 depth five", 64'(v[8:0]), 5);
  endtask

  task automatic t_flags;
    logic [15:0] v;
    pipeReset(5);
    rdReg(1'b0, v);
    chk(v[13:12] == 2'b01, "R4 empty after reset", 64'(v[13:12]), 1);
    fire(1'b0);
    rdReg(1'b1, v);
    chk(v[7:0] == 0 && v[14] == 1'b0, "R4 early trigger ignored", 64'(v), 64'h1000);
    repeat (3) tick;
    rdReg(1'b0, v);
    chk(v[13] == 1'b0, "R4 not full at D-1", 64'(v[13]), 0);
    tick;
    rdReg(1'b0, v);
    chk(v[13:12] == 2'b10, "R4 full at D", 64'(v[13:12]), 2);
  endtask

  task automatic t_no_start;
    logic [15:0] v;
    fire(1'b1);
    roReq = 1'b1;
    tick;
    roReq = 1'b0;
    chk(roAck === 1'b0, "R9 no ack before start", 64'(roAck), 0);
    rdReg(1'b1, v);
    chk(v[7:0] == 8'd1, "R9 entry kept", 64'(v[7:0]), 1);
  endtask

  task automatic t_read;
    logic [15:0] v;
    startRo;
    chk(validPattern === 3'b111, "R10 all links valid", 64'(validPattern), 7);
    readEntry("R3 delay five");
    rdReg(1'b1, v);
    chk(v[7:0] == 0 && v[12] == 1'b1, "R8 entry removed", 64'(v), 64'h1000);
    roReq = 1'b1;
    tick;
    roReq = 1'b0;
    chk(roAck === 1'b0, "R9 no ack when empty", 64'(roAck), 0);
  endtask

  task automatic t_depth_change;
    logic [15:0] v;
    wrDepth(16'd9);
    rdReg(1'b0, v);
    chk(v[8:0] == 9'd9 && v[13] == 1'b1, "R5 new depth stored, still full", 64'(v), 64'h2009);
    fire(1'b1);
    readEntry("R5 old delay kept");
    pipeReset(9);
    repeat (8) tick;
    rdReg(1'b0, v);
    chk(v[13] == 1'b0, "R5 new depth not full at 8", 64'(v[13]), 0);
    tick;
    fire(1'b1);
    readEntry("R5 delay nine");
  endtask

  task automatic t_patterns;
    fire(1'b1);
    fire(1'b1);
    tick;
    fire(1'b1);
    for (int k = 0; k < 3; k++) readEntry("R3 burst");
    zeroMask = 3'b010;
    repeat (12) tick;
    fire(1'b1);
    zeroMask = 3'b000;
    startRo;
    chk(validPattern === 3'b101, "R10 zero link", 64'(validPattern), 5);
    readEntry("R3 masked");
    startRo;
    chk(validPattern === 3'b000, "R10 empty pattern", 64'(validPattern), 0);
  endtask

  task automatic t_full;
    logic [15:0] v;
    for (int k = 0; k < 128; k++) fire(1'b1);
    rdReg(1'b1, v);
    chk(v[7:0] == 8'h80 && v[14:12] == 3'b010, "R6 full status", 64'(v), 64'h2080);
    fire(1'b1);
    rdReg(1'b1, v);
    chk(v[7:0] == 8'h80 && v[14] == 1'b1, "R7 dropped and flagged", 64'(v), 64'h6080);
    for (int k = 0; k < 128; k++) readEntry("R7 contents intact");
    rdReg(1'b1, v);
    chk(v[14:12] == 3'b101 && v[7:0] == 0, "R7 sticky after drain", 64'(v), 64'h5000);
  endtask

  initial begin
    @(negedge clk);
    t_reset;
    t_depth_rw;
    t_flags;
    t_no_start;
    t_read;
    t_depth_change;
    t_patterns;
    t_full;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule